// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter

This block is the transmit side of a master-clocked synchronous serial port. Software reaches it through a small register port with four byte-wide locations. A one-byte holding register sits in front of an 8-bit shift register. The block drives a serial data line and a synchronization clock derived from the system clock, and it raises two interrupt requests. One request says the holding register is free. The other says the line went idle with nothing left to send.

A byte is queued in three steps. Software reads the status register and sees the empty flag at 1, writes the holding register, then writes 0 to the empty flag. Writing the byte alone changes nothing. An external transfer controller can instead write the holding register over a dedicated strobe, and that strobe also clears the empty flag. If a byte is queued before the current frame's last bit ends, the next frame starts with no idle clock period. Clearing the enable bit resets the shifter and forces both flags to 1.

Register map (2-bit address): 0 = holding register (write; read returns the last byte written), 1 = status (bit 0 empty, bit 1 end), 2 = control (bit 0 enable), 3 = divider (half-period count minus one).

Top module: `csync_tx`

## Requirements
- R1: After reset, status reads 0x03, control reads 0x00, and sclk_o and sdata_o are 1, while sdata_oe_o, irq_empty_o and irq_end_o are 0.
- R2: sdata_oe_o follows control bit 0 (enable), starting in the cycle after the control write.
- R3: A frame carries 8 bits, least significant bit first. sclk_o idles high and gives exactly 8 low-then-high pulses per frame. sdata_o changes only when sclk_o falls, so each bit is valid at the rising edge.
- R4: Each half period of sclk_o lasts (divider + 1) system clock cycles.
- R5: Writing the holding register (address 0) neither clears the empty flag nor starts a frame.
- R6: A write of 0 to a status flag bit clears that flag only if the last status read saw the flag at 1 and no status write has happened since. Any other status write is ignored.
- R7: When the shifter takes a byte, the empty flag returns to 1 and irq_empty_o asserts. With the shifter idle, this happens one cycle after the edge that cleared the flag, and in that cycle sclk_o falls and sdata_o carries bit 0.
- R8: When a frame's last bit ends with the empty flag at 1, the end flag sets and irq_end_o asserts. From the clearing edge to the cycle that shows the end flag takes 1 + 16*(divider+1) cycles.
- R9: A byte queued before the last bit ends goes out back to back, so two frames take 1 + 32*(divider+1) cycles from the first clearing edge to the end flag.
- R10: Clearing the empty flag, by software or by the controller strobe, also clears the end flag.
- R11: A pulse on dma_wr_i loads dma_wdata_i into the holding register and clears the empty flag, which starts a frame with no software step.
- R12: With enable at 0, both flags read 1, both interrupt requests are 0, and the shifter is held reset: a frame in progress is abandoned, sclk_o and sdata_o go to 1 one cycle later, and the frame does not resume on re-enable.
- R13: Between frames, sdata_o holds the level of the last bit sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (arms flag clears) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from address |
| dma_wr_i | input | 1 | Transfer-controller write strobe for the holding register |
| dma_wdata_i | input | 8 | Transfer-controller write data |
| sclk_o | output | 1 | Synchronization clock, idles high |
| sdata_o | output | 1 | Serial data |
| sdata_oe_o | output | 1 | Data pin assigned to the transmitter |
| irq_empty_o | output | 1 | Holding register empty request |
| irq_end_o | output | 1 | Transmit end request |

## Verification
Each result has a fixed due cycle, counted from the clock edge that performs the clearing write or strobe. irq_empty_o falls in the cycle after that edge and rises again, with sclk_o low and bit 0 on sdata_o, one cycle later. The end flag is due 1 + 16*(divider+1) cycles after the edge for one frame, or 1 + 32*(divider+1) for two back-to-back frames. The bench keeps a cycle counter that it reads on falling clock edges. It compares these counts exactly and also checks the flag in the cycle just before the due cycle. Serial data is captured at each rising sclk_o edge and compared with the queued bytes.

// File: rtl/csync_pkg.sv
package csync_pkg;
  typedef enum logic [1:0] {
    ADR_DATA = 2'd0,
    ADR_STAT = 2'd1,
    ADR_CTRL = 2'd2,
    ADR_DIV  = 2'd3
  } reg_adr_e;

  localparam int unsigned STAT_EMPTY = 0;
  localparam int unsigned STAT_END   = 1;
  localparam int unsigned CTRL_EN    = 0;
endpackage

// File: rtl/csync_regs.sv
module csync_regs
  import csync_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned DIV_RST = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              dma_wr_i,
  input  logic [DATA_W-1:0] dma_wdata_i,
  input  logic              load_i,
  input  logic              fend_i,
  output logic              en_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [DATA_W-1:0] tdr_o,
  output logic              empty_o,
  output logic              end_o
);
  logic              en_q, empty_q, end_q, arm_e_q, arm_t_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] tdr_q;
  logic              stat_wr, stat_rd, clr_e, clr_t;

  assign stat_wr = wr_i && (addr_i == ADR_STAT);
  assign stat_rd = rd_i && (addr_i == ADR_STAT);
  // empty clear: armed software write of 0, or controller reload
  assign clr_e = en_q && ((stat_wr && arm_e_q && !wdata_i[STAT_EMPTY]) ||
                          (dma_wr_i && empty_q));
  assign clr_t = en_q && stat_wr && arm_t_q && !wdata_i[STAT_END];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      div_q   <= DIV_W'(DIV_RST);
      tdr_q   <= '0;
      empty_q <= 1'b1;
      end_q   <= 1'b1;
      arm_e_q <= 1'b0;
      arm_t_q <= 1'b0;
    end else begin
      if (wr_i && addr_i == ADR_CTRL) en_q  <= wdata_i[CTRL_EN];
      if (wr_i && addr_i == ADR_DIV)  div_q <= wdata_i[DIV_W-1:0];
      if (dma_wr_i)                   tdr_q <= dma_wdata_i;
      else if (wr_i && addr_i == ADR_DATA) tdr_q <= wdata_i;

      if (!en_q || stat_wr) begin
        arm_e_q <= 1'b0;
        arm_t_q <= 1'b0;
      end else if (stat_rd) begin
        arm_e_q <= empty_q;
        arm_t_q <= end_q;
      end

      if (!en_q) begin
        empty_q <= 1'b1;
        end_q   <= 1'b1;
      end else begin
        if (load_i)     empty_q <= 1'b1;
        else if (clr_e) empty_q <= 1'b0;
        // queued byte wins over end of frame
        if (clr_e)       end_q <= 1'b0;
        else if (fend_i) end_q <= 1'b1;
        else if (clr_t)  end_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADR_DATA: rdata_o = tdr_q;
      ADR_STAT: begin
        rdata_o[STAT_EMPTY] = empty_q;
        rdata_o[STAT_END]   = end_q;
      end
      ADR_CTRL: rdata_o[CTRL_EN] = en_q;
      ADR_DIV:  rdata_o = DATA_W'(div_q);
      default:  rdata_o = '0;
    endcase
  end

  assign en_o    = en_q;
  assign div_o   = div_q;
  assign tdr_o   = tdr_q;
  assign empty_o = empty_q;
  assign end_o   = end_q;
endmodule

// File: rtl/csync_shift.sv
module csync_shift #(
  parameter int unsigned FRAME_BITS = 8,
  parameter int unsigned DIV_W      = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  pend_i,
  input  logic [DIV_W-1:0]      div_i,
  input  logic [FRAME_BITS-1:0] data_i,
  output logic                  load_o,
  output logic                  fend_o,
  output logic                  sclk_o,
  output logic                  sdata_o
);
  localparam int unsigned BIT_W = $clog2(FRAME_BITS);

  logic                  busy_q, sclk_q, sd_q;
  logic [DIV_W-1:0]      cnt_q;
  logic [BIT_W-1:0]      bit_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic                  tick, frame_done;

  assign tick       = busy_q && (cnt_q == div_i);
  assign frame_done = tick && sclk_q && (bit_q == BIT_W'(FRAME_BITS - 1));
  assign load_o     = en_i && pend_i && (!busy_q || frame_done);
  assign fend_o     = en_i && frame_done && !pend_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b1;
      sd_q   <= 1'b1;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
    end else if (!en_i) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b1;
      sd_q   <= 1'b1;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      sclk_q <= 1'b0;
      sd_q   <= data_i[0];
      sh_q   <= data_i;
      cnt_q  <= '0;
      bit_q  <= '0;
    end else if (fend_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (tick) begin
      cnt_q <= '0;
      if (!sclk_q) begin
        sclk_q <= 1'b1;
      end else begin
        sclk_q <= 1'b0;
        bit_q  <= bit_q + 1'b1;
        sh_q   <= sh_q >> 1;
        sd_q   <= sh_q[1];
      end
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sclk_o  = sclk_q;
  assign sdata_o = sd_q;
endmodule

// File: rtl/csync_tx.sv
module csync_tx
  import csync_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned DIV_RST = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              dma_wr_i,
  input  logic [DATA_W-1:0] dma_wdata_i,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic              irq_empty_o,
  output logic              irq_end_o
);
  logic              en, empty, tend, load, fend;
  logic [DIV_W-1:0]  div;
  logic [DATA_W-1:0] tdr;

  csync_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .DIV_RST(DIV_RST)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .rd_i       (reg_rd_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .dma_wr_i   (dma_wr_i),
    .dma_wdata_i(dma_wdata_i),
    .load_i     (load),
    .fend_i     (fend),
    .en_o       (en),
    .div_o      (div),
    .tdr_o      (tdr),
    .empty_o    (empty),
    .end_o      (tend)
  );

  csync_shift #(.FRAME_BITS(DATA_W), .DIV_W(DIV_W)) i_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .pend_i (!empty),
    .div_i  (div),
    .data_i (tdr),
    .load_o (load),
    .fend_o (fend),
    .sclk_o (sclk_o),
    .sdata_o(sdata_o)
  );

  assign sdata_oe_o  = en;
  assign irq_empty_o = en && empty;
  assign irq_end_o   = en && tend;
endmodule

// File: rtl/csync_tx_chk.sv
module csync_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sclk_o,
  input logic sdata_o,
  input logic sdata_oe_o,
  input logic irq_empty_o,
  input logic irq_end_o
);
  AST_DATA_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni || !sdata_oe_o)
    !$stable(sdata_o) |-> !sclk_o); // R3

  AST_LOAD_DRIVES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_empty_o) && $past(sdata_oe_o)) |-> !sclk_o); // R7

  AST_END_IMPLIES_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_end_o |-> irq_empty_o); // R8

  AST_END_LINE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_end_o |-> sclk_o); // R13

  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdata_oe_o |=> (sclk_o && sdata_o)); // R12
endmodule

bind csync_tx csync_tx_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sclk_o     (sclk_o),
  .sdata_o    (sdata_o),
  .sdata_oe_o (sdata_oe_o),
  .irq_empty_o(irq_empty_o),
  .irq_end_o  (irq_end_o)
);

// File: tb/test_csync_tx.sv
module test_csync_tx;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] reg_addr_i = '0;
  logic       reg_wr_i = 1'b0, reg_rd_i = 1'b0, dma_wr_i = 1'b0;
  logic [7:0] reg_wdata_i = '0, dma_wdata_i = '0, reg_rdata_o;
  logic       sclk_o, sdata_o, sdata_oe_o, irq_empty_o, irq_end_o;

  int checks = 0, errors = 0;
  int cyc = 0;
  logic [7:0] exp_q[$];
  logic [7:0] cap_q[$];
  logic [7:0] mon_sh = '0;
  int         mon_n = 0;
  logic       sclk_prev = 1'b1;

  always #4 clk_i = ~clk_i;

  csync_tx i_csync_tx (.*);

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual timeout, expected run to complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // capture at each rising sclk edge
  always @(negedge clk_i) begin
    if (!sdata_oe_o) mon_n = 0;
    else if (sclk_o && !sclk_prev) begin
      mon_sh = {sdata_o, mon_sh[7:1]};
      mon_n++;
      if (mon_n == 8) begin cap_q.push_back(mon_sh); mon_n = 0; end
    end
    sclk_prev = sclk_o;
  end

  function automatic int end_due(input int div, input int frames);
    return 1 + 16 * (div + 1) * frames;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk_i);
    reg_addr_i = a; reg_rd_i = 1'b1;
    #1 v = reg_rdata_o;
    @(negedge clk_i);
    reg_rd_i = 1'b0;
  endtask

  task automatic dma_put(input logic [7:0] d);
    @(negedge clk_i);
    dma_wdata_i = d; dma_wr_i = 1'b1;
    @(negedge clk_i);
    dma_wr_i = 1'b0;
  endtask

  // read status (arm), write data, clear empty; returns at negedge after clearing edge
  task automatic queue_sw(input logic [7:0] d);
    logic [7:0] s;
    reg_rd(2'd1, s);
    reg_wr(2'd0, d);
    reg_wr(2'd1, 8'h00);
    exp_q.push_back(d);
  endtask

  task automatic wait_end(output int t);
    int n = 0;
    while (!irq_end_o && n < 5000) begin @(negedge clk_i); n++; end
    t = cyc;
  endtask

  task automatic wait_empty();
    int n = 0;
    while (!irq_empty_o && n < 5000) begin @(negedge clk_i); n++; end
  endtask

  task automatic cmp_caps(input string req);
    while (exp_q.size() > 0) begin
      logic [7:0] e = exp_q.pop_front();
      if (cap_q.size() == 0) chk(req, -1, e);
      else chk(req, cap_q.pop_front(), e);
    end
    chk(req, cap_q.size(), 0);
  endtask

  initial begin
    logic [7:0] v;
    int t0, t1, lows;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    reg_rd(2'd1, v); chk("R1 status", v, 8'h03);
    reg_rd(2'd2, v); chk("R1 ctrl", v, 8'h00);
    chk("R1 sclk", sclk_o, 1); chk("R1 sdata", sdata_o, 1);
    chk("R1 oe", sdata_oe_o, 0);
    chk("R1 irqs", {irq_empty_o, irq_end_o}, 2'b00);

    // R2 enable
    reg_wr(2'd3, 8'd1);
    reg_wr(2'd2, 8'h01);
    chk("R2 oe", sdata_oe_o, 1);
    chk("R2 irq_empty", irq_empty_o, 1);

    // R5 data write alone
    reg_wr(2'd0, 8'hA5);
    lows = 0;
    repeat (30) begin @(negedge clk_i); if (!sclk_o) lows++; end
    chk("R5 no clock", lows, 0);
    chk("R5 empty kept", irq_empty_o, 1);

    // R7/R8 single frame, divider 1
    queue_sw(8'hA5);
    t0 = cyc;
    chk("R7 empty low", irq_empty_o, 0);
    @(negedge clk_i);
    chk("R7 empty back", irq_empty_o, 1);
    chk("R7 sclk fall", sclk_o, 0);
    chk("R7 bit0", sdata_o, 1);
    // R4 half period = 2 cycles
    @(negedge clk_i); chk("R4 low held", sclk_o, 0);
    @(negedge clk_i); chk("R4 rise", sclk_o, 1);
    wait_end(t1);
    chk("R8 end due", t1 - t0, end_due(1, 1));
    cmp_caps("R3 frame");
    chk("R13 idle level", sdata_o, 1);

    // R6 unarmed clear ignored, armed clear consumed by other write
    reg_wr(2'd1, 8'h00);
    reg_rd(2'd1, v); chk("R6 unarmed", v, 8'h03);
    reg_wr(2'd1, 8'h03);
    reg_wr(2'd1, 8'h00);
    repeat (10) @(negedge clk_i);
    reg_rd(2'd1, v); chk("R6 consumed arm", v, 8'h03);
    chk("R6 no clock", sclk_o, 1);
    // armed clear of end only
    reg_wr(2'd1, 8'h01);
    reg_rd(2'd1, v); chk("R6 end cleared", v, 8'h01);

    // R9 back to back, divider 0, end timing; R10 end cleared by queue
    reg_wr(2'd3, 8'd0);
    queue_sw(8'h3C);
    t0 = cyc;
    wait_empty();
    queue_sw(8'h81);
    chk("R10 end low", irq_end_o, 0);
    while (cyc - t0 < end_due(0, 2) - 1) @(negedge clk_i);
    chk("R9 not early", irq_end_o, 0);
    @(negedge clk_i);
    chk("R9 end due", irq_end_o, 1);
    chk("R9 cycles", cyc - t0, end_due(0, 2));
    cmp_caps("R9 data");
    chk("R13 idle bit7", sdata_o, 1);

    // R11 controller reload, divider 3, R4 timing
    reg_wr(2'd3, 8'd3);
    dma_put(8'h7E);
    exp_q.push_back(8'h7E);
    t0 = cyc;
    chk("R11 empty cleared", irq_empty_o, 0);
    chk("R10 end by dma", irq_end_o, 0);
    @(negedge clk_i);
    chk("R11 bit0", sdata_o, 0);
    repeat (3) @(negedge clk_i);
    chk("R4 low 4", sclk_o, 0);
    @(negedge clk_i);
    chk("R4 rise 4", sclk_o, 1);
    wait_end(t1);
    chk("R8 end div3", t1 - t0, end_due(3, 1));
    cmp_caps("R11 data");
    chk("R13 idle zero", sdata_o, 0);

    // R12 disable mid frame
    reg_wr(2'd3, 8'd1);
    queue_sw(8'h00);
    void'(exp_q.pop_back());
    repeat (5) @(negedge clk_i);
    reg_wr(2'd2, 8'h00);
    chk("R12 irqs", {irq_empty_o, irq_end_o}, 2'b00);
    chk("R2 oe off", sdata_oe_o, 0);
    @(negedge clk_i);
    chk("R12 sclk", sclk_o, 1); chk("R12 sdata", sdata_o, 1);
    reg_rd(2'd1, v); chk("R12 flags", v, 8'h03);
    reg_wr(2'd2, 8'h01);
    lows = 0;
    repeat (20) begin @(negedge clk_i); if (!sclk_o) lows++; end
    chk("R12 no resume", lows, 0);
    chk("R12 no capture", cap_q.size(), 0);

    // random traffic
    for (int it = 0; it < 14; it++) begin
      int d = $urandom % 4;
      int n = 1 + ($urandom % 2);
      logic [7:0] last = '0;
      reg_wr(2'd3, 8'(d));
      for (int k = 0; k < n; k++) begin
        logic [7:0] b = 8'($urandom);
        wait_empty();
        if ($urandom % 2) begin dma_put(b); exp_q.push_back(b); end
        else queue_sw(b);
        last = b;
      end
      wait_end(t1);
      cmp_caps("R3 random");
      chk("R13 random idle", sdata_o, last[7]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule